// File: doc/BRIEF.md
# Core Power Domain Sequencer

This block runs the power-up and power-down procedure of a single processor core's power domain. It owns the core's reset line, its power-on reset line, the L1 reset-disable strobe, the isolation gate that clamps the domain's outputs while it is unpowered, and an 8-bit code that drives a staged header power switch. A one-cycle start pulse, qualified by a direction bit, launches a sequence. Every step is separated from the next by a dwell time given in microseconds and converted to clock cycles through a cycles-per-microsecond parameter. A one-cycle done pulse ends the sequence.

On the way up, the switch is opened in six partial stages so that the inrush current stays bounded. The block then waits until the switch reports fully open before it lifts isolation and releases the resets. On the way down, the domain is isolated first and then the switch is closed in one step. The switch's own readback comes in on a separate input, which in a system is the switch controller echoing the code it holds. When the readback already shows the target state, the switch phase is skipped.

Top module: `core_pwr_seq`

## Requirements
- R1: A start pulse is accepted only when `busy_o` is low. `busy_o` is high from the cycle after acceptance until the done cycle. A start pulse arriving while `busy_o` is high has no effect on any output.
- R2: Resets are active low (0 = held in reset). On power-up, `core_rst_n_o` goes to 0 in the cycle after acceptance. After 10 µs, `por_rst_n_o` goes to 0. After another 10 µs, the switch phase begins.
- R3: The switch is released by driving `clamp_o` through 0xFE, 0xF8, 0xE0, 0xC0, 0x80, 0x00 in that order. The dwell is 20 µs on 0xFE, 10 µs on each of the four middle codes, and 20 µs on 0x00.
- R4: After the 0x00 dwell, the sequence holds until `clamp_rd_i` equals 0x00. Isolation stays set while it waits.
- R5: On power-up, if `clamp_rd_i` already reads 0x00 when the switch phase would start, no clamp code is written. On power-down, if it already reads 0xFF when the switch phase would start, no clamp code is written and the sequence ends at that point.
- R6: After the switch is open, `iso_gate_o` goes to 0 (1 = isolated). 20 µs later `por_rst_n_o` goes to 1. 10 µs later `core_rst_n_o` goes to 1. 10 µs after that the done cycle follows.
- R7: On power-down, `iso_gate_o` goes to 1 in the cycle after acceptance. After 20 µs, `clamp_o` becomes 0xFF. After 30 µs, the sequence holds until `clamp_rd_i` equals 0xFF, then ends. The reset outputs are not touched.
- R8: `done_o` is a single-cycle pulse in the first idle cycle. `pwr_on_o` becomes 1 with a power-up done and 0 with a power-down done.
- R9: After reset: `core_rst_n_o`=0, `por_rst_n_o`=0, `l1_rst_dis_o`=1, `iso_gate_o`=1, `clamp_o`=0xFF, `busy_o`=0, `done_o`=0, `pwr_on_o`=0.
- R10: `l1_rst_dis_o` goes to 0 at the point where the switch phase of a power-up begins, whether or not that phase is skipped. It never returns to 1 except through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a sequence |
| up_i | input | 1 | Direction with start: 1 = power up, 0 = power down |
| clamp_rd_i | input | 8 | Readback of the code held by the power switch |
| core_rst_n_o | output | 1 | Core reset, active low |
| por_rst_n_o | output | 1 | Core power-on reset, active low |
| l1_rst_dis_o | output | 1 | L1 reset-disable strobe |
| iso_gate_o | output | 1 | Output isolation, 1 = isolated |
| clamp_o | output | 8 | Staged power-switch code, 0xFF = off, 0x00 = fully on |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pwr_on_o | output | 1 | Domain powered: set by power-up done, cleared by power-down done |

## Verification
Every step of the sequence is one state plus one dwell counter, so most internal faults show up directly on the ports. A wrong stage index puts a wrong or repeated clamp code on `clamp_o` when the current dwell expires. A miscounted dwell moves the next reset or isolation edge by that many cycles. A wrong poll or skip decision lifts isolation while the readback is still nonzero, or writes codes that should have been skipped. A cycle-accurate reference model compares every output on every clock, so a fault appears no later than the first dwell boundary after it arises, and a stuck counter shows as `busy_o` that never falls.

// File: rtl/core_pwr_seq_pkg.sv
package core_pwr_seq_pkg;

    localparam int unsigned LADDER_STEPS = 6;
    localparam int unsigned STAGE_W      = $clog2(LADDER_STEPS);

    localparam logic [7:0] CLAMP_OPEN = 8'h00;
    localparam logic [7:0] CLAMP_SHUT = 8'hFF;

    typedef enum logic [3:0] {
        S_IDLE,
        S_UP_CRST,
        S_UP_PRST,
        S_UP_LADDER,
        S_UP_POLL,
        S_UP_ISO,
        S_UP_PREL,
        S_UP_CREL,
        S_DN_ISO,
        S_DN_ENG,
        S_DN_POLL
    } seq_state_e;

    typedef struct packed {
        seq_state_e         state;
        logic [STAGE_W-1:0] stage;
        logic               core_rst_n;
        logic               por_rst_n;
        logic               l1_rst_dis;
        logic               iso_gate;
        logic [7:0]         clamp;
        logic               done;
        logic               pwr_on;
    } seq_regs_t;

    // Switch release codes, widest gate opening last.
    function automatic logic [7:0] ladder_code(input logic [STAGE_W-1:0] idx);
        case (idx)
            'd0:     return 8'hFE;
            'd1:     return 8'hF8;
            'd2:     return 8'hE0;
            'd3:     return 8'hC0;
            'd4:     return 8'h80;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/dwell_timer.sv
module dwell_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = load_val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/clamp_ladder.sv
module clamp_ladder
    import core_pwr_seq_pkg::*;
#(
    parameter int unsigned CYC_PER_US = 4,
    parameter int unsigned STEP_US    = 10,
    parameter int unsigned SETTLE_US  = 20,
    parameter int unsigned CNT_W      = 8
) (
    input  logic [STAGE_W-1:0] idx_i,
    output logic [7:0]         code_o,
    output logic [CNT_W-1:0]   dwell_m1_o,
    output logic               last_o
);

    localparam logic [STAGE_W-1:0] LAST_IDX   = STAGE_W'(LADDER_STEPS - 1);
    localparam logic [CNT_W-1:0]   EDGE_DW_M1 = CNT_W'(SETTLE_US * CYC_PER_US - 1);
    localparam logic [CNT_W-1:0]   MID_DW_M1  = CNT_W'(STEP_US * CYC_PER_US - 1);

    always_comb begin
        code_o     = ladder_code(idx_i);
        last_o     = (idx_i == LAST_IDX);
        // First and last stages settle longer than the intermediate ones.
        dwell_m1_o = (idx_i == '0 || last_o) ? EDGE_DW_M1 : MID_DW_M1;
    end

endmodule

// File: rtl/core_pwr_seq.sv
module core_pwr_seq
    import core_pwr_seq_pkg::*;
#(
    parameter int unsigned CYC_PER_US = 4,
    parameter int unsigned STEP_US    = 10,
    parameter int unsigned SETTLE_US  = 20,
    parameter int unsigned ENGAGE_US  = 30
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       up_i,
    input  logic [7:0] clamp_rd_i,
    output logic       core_rst_n_o,
    output logic       por_rst_n_o,
    output logic       l1_rst_dis_o,
    output logic       iso_gate_o,
    output logic [7:0] clamp_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       pwr_on_o
);

    localparam int unsigned STEP_CYC   = STEP_US * CYC_PER_US;
    localparam int unsigned SETTLE_CYC = SETTLE_US * CYC_PER_US;
    localparam int unsigned ENGAGE_CYC = ENGAGE_US * CYC_PER_US;
    localparam int unsigned LONG_A     = (STEP_CYC > SETTLE_CYC) ? STEP_CYC : SETTLE_CYC;
    localparam int unsigned LONGEST    = (LONG_A > ENGAGE_CYC) ? LONG_A : ENGAGE_CYC;
    localparam int unsigned CNT_W      = $clog2(LONGEST + 1);

    localparam logic [CNT_W-1:0] STEP_M1   = CNT_W'(STEP_CYC - 1);
    localparam logic [CNT_W-1:0] SETTLE_M1 = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] ENGAGE_M1 = CNT_W'(ENGAGE_CYC - 1);

    localparam seq_regs_t RESET_VAL = '{
        state:      S_IDLE,
        stage:      '0,
        core_rst_n: 1'b0,
        por_rst_n:  1'b0,
        l1_rst_dis: 1'b1,
        iso_gate:   1'b1,
        clamp:      CLAMP_SHUT,
        done:       1'b0,
        pwr_on:     1'b0
    };

    seq_regs_t          d, q;
    logic               tmr_load;
    logic [CNT_W-1:0]   tmr_val;
    logic               tmr_zero;
    logic [STAGE_W-1:0] lad_idx;
    logic [7:0]         lad_code;
    logic [CNT_W-1:0]   lad_dwell_m1;
    logic               lad_last;

    dwell_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    // Looks up the stage about to be entered: stage 0 from outside the ladder.
    assign lad_idx = (q.state == S_UP_LADDER) ? STAGE_W'(q.stage + 1'b1) : '0;

    clamp_ladder #(
        .CYC_PER_US (CYC_PER_US),
        .STEP_US    (STEP_US),
        .SETTLE_US  (SETTLE_US),
        .CNT_W      (CNT_W)
    ) u_ladder (
        .idx_i      (lad_idx),
        .code_o     (lad_code),
        .dwell_m1_o (lad_dwell_m1),
        .last_o     (lad_last)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (q.state)
            S_IDLE: if (start_i) begin
                tmr_load = 1'b1;
                if (up_i) begin
                    d.state      = S_UP_CRST;
                    d.core_rst_n = 1'b0;
                    tmr_val      = STEP_M1;
                end else begin
                    d.state    = S_DN_ISO;
                    d.iso_gate = 1'b1;
                    tmr_val    = SETTLE_M1;
                end
            end
            S_UP_CRST: if (tmr_zero) begin
                d.state     = S_UP_PRST;
                d.por_rst_n = 1'b0;
                tmr_load    = 1'b1;
                tmr_val     = STEP_M1;
            end
            S_UP_PRST: if (tmr_zero) begin
                d.l1_rst_dis = 1'b0;
                tmr_load     = 1'b1;
                if (clamp_rd_i == CLAMP_OPEN) begin
                    d.state    = S_UP_ISO;
                    d.iso_gate = 1'b0;
                    tmr_val    = SETTLE_M1;
                end else begin
                    d.state = S_UP_LADDER;
                    d.stage = '0;
                    d.clamp = lad_code;
                    tmr_val = lad_dwell_m1;
                end
            end
            S_UP_LADDER: if (tmr_zero) begin
                if (q.stage == STAGE_W'(LADDER_STEPS - 1)) begin
                    d.state = S_UP_POLL;
                end else begin
                    d.stage  = lad_idx;
                    d.clamp  = lad_code;
                    tmr_load = 1'b1;
                    tmr_val  = lad_dwell_m1;
                end
            end
            S_UP_POLL: if (clamp_rd_i == CLAMP_OPEN) begin
                d.state    = S_UP_ISO;
                d.iso_gate = 1'b0;
                tmr_load   = 1'b1;
                tmr_val    = SETTLE_M1;
            end
            S_UP_ISO: if (tmr_zero) begin
                d.state     = S_UP_PREL;
                d.por_rst_n = 1'b1;
                tmr_load    = 1'b1;
                tmr_val     = STEP_M1;
            end
            S_UP_PREL: if (tmr_zero) begin
                d.state      = S_UP_CREL;
                d.core_rst_n = 1'b1;
                tmr_load     = 1'b1;
                tmr_val      = STEP_M1;
            end
            S_UP_CREL: if (tmr_zero) begin
                d.state  = S_IDLE;
                d.done   = 1'b1;
                d.pwr_on = 1'b1;
            end
            S_DN_ISO: if (tmr_zero) begin
                if (clamp_rd_i == CLAMP_SHUT) begin
                    d.state  = S_IDLE;
                    d.done   = 1'b1;
                    d.pwr_on = 1'b0;
                end else begin
                    d.state  = S_DN_ENG;
                    d.clamp  = CLAMP_SHUT;
                    tmr_load = 1'b1;
                    tmr_val  = ENGAGE_M1;
                end
            end
            S_DN_ENG: if (tmr_zero) d.state = S_DN_POLL;
            S_DN_POLL: if (clamp_rd_i == CLAMP_SHUT) begin
                d.state  = S_IDLE;
                d.done   = 1'b1;
                d.pwr_on = 1'b0;
            end
            default: d = RESET_VAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RESET_VAL;
        else        q <= d;
    end

    assign core_rst_n_o = q.core_rst_n;
    assign por_rst_n_o  = q.por_rst_n;
    assign l1_rst_dis_o = q.l1_rst_dis;
    assign iso_gate_o   = q.iso_gate;
    assign clamp_o      = q.clamp;
    assign busy_o       = (q.state != S_IDLE);
    assign done_o       = q.done;
    assign pwr_on_o     = q.pwr_on;

    // Done is a one-cycle pulse in an idle cycle.
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);
    assert_pwr_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_on_o) |-> done_o);
    // Isolation lifts only once the switch reported fully open.
    assert_iso_after_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iso_gate_o) |-> ($past(clamp_rd_i) == CLAMP_OPEN));
    assert_por_after_iso_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(por_rst_n_o) |-> !iso_gate_o);
    assert_core_after_por_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst_n_o) |-> por_rst_n_o);
    // Release codes only ever clear bits relative to the previous code.
    assert_clamp_monotone_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(clamp_o) && clamp_o != CLAMP_SHUT) |-> ((clamp_o & $past(clamp_o)) == clamp_o));
    assert_clamp_shut_iso_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clamp_o == CLAMP_SHUT) |-> iso_gate_o);
    assert_l1_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !l1_rst_dis_o |=> !l1_rst_dis_o);

endmodule

// File: tb/core_pwr_seq_bench.sv
module core_pwr_seq_bench;

    localparam int C    = 4;
    localparam int D10  = 10 * C;
    localparam int D20  = 20 * C;
    localparam int D30  = 30 * C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       up_i = 1'b0;
    logic [7:0] clamp_rd_i;
    logic       core_rst_n_o, por_rst_n_o, l1_rst_dis_o, iso_gate_o;
    logic [7:0] clamp_o;
    logic       busy_o, done_o, pwr_on_o;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;

    // Switch echo with selectable lag and an override.
    logic [7:0] echo [0:3];
    int         lag = 1;
    bit         force_en = 1'b0;
    logic [7:0] force_val = 8'h00;

    always #5 clk = ~clk;

    core_pwr_seq #(.CYC_PER_US(C), .STEP_US(10), .SETTLE_US(20), .ENGAGE_US(30)) u_core_pwr_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .up_i(up_i), .clamp_rd_i(clamp_rd_i),
        .core_rst_n_o(core_rst_n_o), .por_rst_n_o(por_rst_n_o), .l1_rst_dis_o(l1_rst_dis_o),
        .iso_gate_o(iso_gate_o), .clamp_o(clamp_o), .busy_o(busy_o), .done_o(done_o),
        .pwr_on_o(pwr_on_o));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) echo[i] <= 8'hFF;
        end else begin
            echo[0] <= clamp_o;
            for (int i = 1; i < 4; i++) echo[i] <= echo[i-1];
        end
    end
    assign clamp_rd_i = force_en ? force_val : echo[lag-1];

    // ---------------- reference model ----------------
    logic       e_core = 0, e_por = 0, e_l1 = 1, e_iso = 1, e_busy = 0, e_done = 0, e_pwr = 0;
    logic [7:0] e_clamp = 8'hFF;
    logic [7:0] codes [0:5] = '{8'hFE, 8'hF8, 8'hE0, 8'hC0, 8'h80, 8'h00};
    int         dwells [0:5] = '{D20, D10, D10, D10, D10, D20};

    task automatic wait_n(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic model_up();
        e_busy = 1; e_core = 0;
        wait_n(D10); e_por = 0;
        wait_n(D10); e_l1 = 0;
        if (clamp_rd_i != 8'h00) begin
            for (int i = 0; i < 6; i++) begin
                e_clamp = codes[i];
                wait_n(dwells[i]);
            end
            do @(posedge clk); while (clamp_rd_i != 8'h00);
        end
        e_iso = 0;
        wait_n(D20); e_por = 1;
        wait_n(D10); e_core = 1;
        wait_n(D10); e_busy = 0; e_done = 1; e_pwr = 1;
    endtask

    task automatic model_down();
        e_busy = 1; e_iso = 1;
        wait_n(D20);
        if (clamp_rd_i != 8'hFF) begin
            e_clamp = 8'hFF;
            wait_n(D30);
            do @(posedge clk); while (clamp_rd_i != 8'hFF);
        end
        e_busy = 0; e_done = 1; e_pwr = 0;
    endtask

    initial begin
        @(posedge rst_n);
        forever begin
            @(posedge clk);
            e_done = 0;
            if (start_i) begin
                if (up_i) model_up();
                else      model_down();
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s cycle %0d actual %h expected %h", tag, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && cyc > 2) begin
            chk("R2 core_rst_n", {7'd0, core_rst_n_o}, {7'd0, e_core});
            chk("R2 por_rst_n",  {7'd0, por_rst_n_o},  {7'd0, e_por});
            chk("R10 l1_rst_dis", {7'd0, l1_rst_dis_o}, {7'd0, e_l1});
            chk("R6 iso_gate",   {7'd0, iso_gate_o},   {7'd0, e_iso});
            chk("R3 clamp",      clamp_o,              e_clamp);
            chk("R1 busy",       {7'd0, busy_o},       {7'd0, e_busy});
            chk("R8 done",       {7'd0, done_o},       {7'd0, e_done});
            chk("R8 pwr_on",     {7'd0, pwr_on_o},     {7'd0, e_pwr});
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            mismatched++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    bit         moved;
    logic [7:0] clamp_ref;

    task automatic pulse_start(input logic dir);
        @(negedge clk);
        up_i = dir; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        while (!done_o) begin
            if (clamp_o !== clamp_ref) moved = 1'b1;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 reset clamp", clamp_o, 8'hFF);
        chk("R9 reset resets", {6'd0, core_rst_n_o, por_rst_n_o}, 8'h00);
        chk("R9 reset l1/iso", {6'd0, l1_rst_dis_o, iso_gate_o}, 8'h03);
        chk("R9 reset busy/done/pwr", {5'd0, busy_o, done_o, pwr_on_o}, 8'h00);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Full power-up, lag 1
        lag = 1;
        pulse_start(1'b1);
        clamp_ref = clamp_o; moved = 0;
        wait_done();
        chk("R8 pwr_on after up", {7'd0, pwr_on_o}, 8'h01);
        chk("R10 l1 low after up", {7'd0, l1_rst_dis_o}, 8'h00);
        chk("R6 released after up", {5'd0, core_rst_n_o, por_rst_n_o, iso_gate_o}, 8'h06);
        @(negedge clk);

        // Power-down with a slow switch; an up request mid-way must be ignored
        lag = 2;
        pulse_start(1'b0);
        repeat (10) @(negedge clk);
        pulse_start(1'b1);
        while (clamp_o != 8'hFF) @(negedge clk);
        force_en = 1'b1; force_val = 8'h00;
        repeat (D30 + 30) @(negedge clk);
        chk("R7 waits for shut readback", {6'd0, busy_o, iso_gate_o}, 8'h03);
        force_en = 1'b0;
        clamp_ref = clamp_o; moved = 0;
        wait_done();
        chk("R7 state after down", {clamp_o}, 8'hFF);
        chk("R7 pwr_on cleared", {6'd0, pwr_on_o, iso_gate_o}, 8'h01);
        chk("R7 resets untouched", {6'd0, core_rst_n_o, por_rst_n_o}, 8'h03);
        repeat (5) @(negedge clk);
        chk("R1 ignored start left idle", {7'd0, busy_o}, 8'h00);

        // Down again: switch already shut, skip
        pulse_start(1'b0);
        clamp_ref = 8'hFF; moved = 0;
        wait_done();
        chk("R5 no clamp write on shut skip", {7'd0, moved}, 8'h00);
        @(negedge clk);

        // Power-up with lag 3 and a late readback
        lag = 3;
        pulse_start(1'b1);
        while (clamp_o != 8'h00) @(negedge clk);
        force_en = 1'b1; force_val = 8'h80;
        repeat (D20 + 40) @(negedge clk);
        chk("R4 isolation held while readback nonzero", {6'd0, busy_o, iso_gate_o}, 8'h03);
        force_en = 1'b0;
        wait_done();
        chk("R8 pwr_on after second up", {7'd0, pwr_on_o}, 8'h01);
        @(negedge clk);

        // Up again: switch already open, skip; then back-to-back down
        pulse_start(1'b1);
        clamp_ref = 8'h00; moved = 0;
        wait_done();
        chk("R5 no clamp write on open skip", {7'd0, moved}, 8'h00);
        chk("R10 l1 stays low", {7'd0, l1_rst_dis_o}, 8'h00);
        up_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R1 start in done cycle accepted", {7'd0, busy_o}, 8'h01);
        clamp_ref = clamp_o; moved = 0;
        wait_done();
        chk("R7 down after back-to-back", clamp_o, 8'hFF);
        repeat (5) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule